// File: doc/BRIEF.md
# Clustered Thread Priority Arbiter

This block decides, for a memory request scheduler, which hardware thread is served first. At the end of every quantum it samples three per-thread counters: memory intensity, row-buffer hit rate and bank-level parallelism. It then sorts the threads into two groups. Threads with low memory intensity form the latency-sensitive group, and every thread in it outranks every other thread. The remaining threads form the bandwidth-sensitive group. Inside that group each thread holds a rank derived from a niceness score. A thread is nicer when its bank-level parallelism is high and its row-buffer hit rate is low.

The bandwidth group's ranks are permuted again at a programmable interval within the quantum, so that no thread keeps the bottom place for long. The permutation method is fixed for the whole quantum. When the niceness values of the group are widely spread, the bottom-ranked thread is lifted to the top one step at a time (insertion). Otherwise a pseudo-random permutation driven by a 16-bit LFSR is applied.

Each cycle the block also picks one entry from a table of pending requests, each tagged with a thread number. The chosen entry belongs to the thread with the best priority.

Top module: `ctpa_arbiter`

## Requirements
- R1: A quantum counter marks the last cycle of a quantum when count+1 >= quantum_len_i. At that clock edge the counters and thresholds are sampled, and prio_o shows the new grouping from the next cycle. A quantum_len_i of 0 or 1 makes every cycle a quantum end.
- R2: A thread with intensity strictly below int_thresh_i (unsigned) is latency-sensitive and its 4-bit prio field equals NTHR (8). A bandwidth-sensitive thread's field holds its rank in 0..nbw-1, where nbw is the size of that group. Larger values are better. The field of thread i sits at prio_o[4i+3:4i], and the counters of thread i at bits [8i+7:8i] of each counter bus.
- R3: The hit rank of a thread counts the threads whose hit rate is lower, plus the threads with an equal hit rate and a lower ID. The parallelism rank is formed the same way. Niceness is the parallelism rank minus the hit rank. After a quantum end the nicest bandwidth thread holds rank nbw-1 and the least nice holds rank 0; equal niceness gives the lower ID the higher rank.
- R4: At a quantum end the method is insertion when (max - min) niceness over the bandwidth group exceeds gap_thresh_i, and random otherwise. An empty bandwidth group selects insertion.
- R5: An insertion shuffle moves the thread at rank nbw-1 to rank 0 and raises every other bandwidth thread by one.
- R6: The LFSR starts at 0xACE1 and steps to {s[14:0], s[15]^s[13]^s[12]^s[10]}. A random shuffle applies two rounds of swaps. The first round swaps the rank pairs (0,1), (2,3), (4,5), (6,7) under LFSR bits 0..3. The second round then swaps (1,2), (3,4), (5,6) under bits 4..6. A pair is swapped only when its bit is set and both ranks are below nbw. The LFSR steps once after each random shuffle and never otherwise.
- R7: A shuffle counter restarts at every quantum end. A shuffle fires in a cycle that is not a quantum end when count+1 >= shuffle_int_i, and the counter then restarts. A shuffle_int_i of 0 disables shuffles. Ranks and groups do not change outside quantum ends and shuffles.
- R8: grant_o is one-hot over the valid request entries (entry e's thread at req_tid_i[3e+2:3e]). It selects the entry whose thread has the largest prio field, then the lowest thread ID, then the lowest entry index. It is all zero when no entry is valid, and it is combinational in the same cycle.
- R9: While rst is high every thread is latency-sensitive (prio field 8), the counters clear, the method becomes insertion and the LFSR reloads its seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intensity_i | input | NTHR*CNT_W | Per-thread memory intensity |
| hit_rate_i | input | NTHR*CNT_W | Per-thread row-buffer hit rate |
| blp_i | input | NTHR*CNT_W | Per-thread bank-level parallelism |
| int_thresh_i | input | CNT_W | Intensity limit for the latency group |
| gap_thresh_i | input | TW+1 | Niceness spread limit choosing insertion |
| quantum_len_i | input | QLEN_W | Quantum length in cycles |
| shuffle_int_i | input | QLEN_W | Shuffle interval in cycles, 0 disables |
| req_valid_i | input | NREQ | Pending request entry valid |
| req_tid_i | input | NREQ*TW | Thread ID of each request entry |
| prio_o | output | NTHR*(TW+1) | Per-thread priority value |
| grant_o | output | NREQ | One-hot granted entry |

## Verification
The bench builds the block with its defaults: eight threads, eight request entries, 8-bit counters and 16-bit cycle limits. It programs quantum lengths of 0 to 30 cycles and shuffle intervals of 0 to 7 cycles. With these settings many quantum ends, insertion rotations and LFSR-driven permutations occur within a few thousand cycles. Small counter ranges force equal hit rates, equal parallelism and equal niceness, which exercises the tie rules. An intensity equal to the limit, a shuffle interval longer than the quantum, and phases where all threads fall in one group bring the remaining boundaries into reach.

// File: rtl/ctpa_pkg.sv
package ctpa_pkg;

    typedef enum logic {
        SHUF_INSERT = 1'b0,
        SHUF_RANDOM = 1'b1
    } shuf_mode_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    // One step of the 16-bit Fibonacci LFSR
    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Insertion move: top rank wraps to the bottom, others rise by one
    function automatic int ins_map(input int r, input int n);
        return (r == n - 1) ? 0 : r + 1;
    endfunction

    // Two rounds of conditional adjacent swaps on rank values
    // (nthr/2 + (nthr-1)/2 bits are used, so nthr must not exceed 16)
    function automatic int rnd_map(input int r, input int n,
                                   input logic [15:0] s, input int nthr);
        int v;
        v = r;
        for (int k = 0; k < nthr / 2; k++) begin
            if ((2 * k + 1) < n && s[k]) begin
                if (v == 2 * k)          v = 2 * k + 1;
                else if (v == 2 * k + 1) v = 2 * k;
            end
        end
        for (int k = 0; k < (nthr - 1) / 2; k++) begin
            if ((2 * k + 2) < n && s[nthr / 2 + k]) begin
                if (v == 2 * k + 1)      v = 2 * k + 2;
                else if (v == 2 * k + 2) v = 2 * k + 1;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/ctpa_ranker.sv
module ctpa_ranker #(
    parameter  int NTHR = 8,
    parameter  int CW   = 8,
    localparam int TW   = $clog2(NTHR)
) (
    input  logic [NTHR*CW-1:0] intensity_i,
    input  logic [NTHR*CW-1:0] hit_i,
    input  logic [NTHR*CW-1:0] blp_i,
    input  logic [CW-1:0]      thr_i,
    input  logic [TW:0]        gap_thr_i,
    output logic [NTHR-1:0]    lat_o,
    output logic [NTHR*TW-1:0] rank_o,
    output logic [TW:0]        nbw_o,
    output logic               ins_o
);

    localparam logic [TW-1:0] ONE_R = 1;
    localparam logic [TW:0]   ONE_N = 1;

    logic [CW-1:0]        inten [NTHR];
    logic [CW-1:0]        hit   [NTHR];
    logic [CW-1:0]        blp   [NTHR];
    logic                 lat   [NTHR];
    logic [TW-1:0]        hr    [NTHR];
    logic [TW-1:0]        br    [NTHR];
    logic [TW-1:0]        rk    [NTHR];
    logic signed [TW+1:0] nice  [NTHR];
    logic signed [TW+1:0] mx, mn;
    logic [TW+1:0]        gap;
    logic                 seen;

    always_comb begin
        nbw_o = '0;
        for (int i = 0; i < NTHR; i++) begin
            inten[i] = intensity_i[i*CW +: CW];
            hit[i]   = hit_i[i*CW +: CW];
            blp[i]   = blp_i[i*CW +: CW];
            lat[i]   = inten[i] < thr_i;
            lat_o[i] = lat[i];
            if (!lat[i]) nbw_o = nbw_o + ONE_N;
        end
        // ordinal ranks of hit rate and bank parallelism, ties by ID
        for (int i = 0; i < NTHR; i++) begin
            hr[i] = '0;
            br[i] = '0;
            for (int j = 0; j < NTHR; j++) begin
                if (j != i) begin
                    if (hit[j] < hit[i] || (hit[j] == hit[i] && j < i)) hr[i] = hr[i] + ONE_R;
                    if (blp[j] < blp[i] || (blp[j] == blp[i] && j < i)) br[i] = br[i] + ONE_R;
                end
            end
            nice[i] = $signed({2'b00, br[i]}) - $signed({2'b00, hr[i]});
        end
        // rank inside the bandwidth group: nicest on top, lower ID wins ties
        for (int i = 0; i < NTHR; i++) begin
            rk[i] = '0;
            if (!lat[i]) begin
                for (int j = 0; j < NTHR; j++) begin
                    if (j != i && !lat[j] &&
                        (nice[j] < nice[i] || (nice[j] == nice[i] && j > i)))
                        rk[i] = rk[i] + ONE_R;
                end
            end
            rank_o[i*TW +: TW] = rk[i];
        end
        // niceness spread of the bandwidth group
        seen = 1'b0;
        mx   = '0;
        mn   = '0;
        for (int i = 0; i < NTHR; i++) begin
            if (!lat[i]) begin
                if (!seen) begin
                    mx = nice[i];
                    mn = nice[i];
                end else begin
                    if (nice[i] > mx) mx = nice[i];
                    if (nice[i] < mn) mn = nice[i];
                end
                seen = 1'b1;
            end
        end
        gap   = mx - mn;
        ins_o = !seen || (gap > {1'b0, gap_thr_i});
    end

endmodule

// File: rtl/ctpa_rank_state.sv
module ctpa_rank_state
    import ctpa_pkg::*;
#(
    parameter  int NTHR = 8,
    parameter  int QW   = 16,
    localparam int TW   = $clog2(NTHR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [QW-1:0]      qlen_i,
    input  logic [QW-1:0]      sint_i,
    input  logic [NTHR-1:0]    snap_lat_i,
    input  logic [NTHR*TW-1:0] snap_rank_i,
    input  logic [TW:0]        snap_nbw_i,
    input  logic               snap_ins_i,
    output logic [NTHR-1:0]    lat_o,
    output logic [NTHR*TW-1:0] rank_o
);

    localparam logic [QW:0] ONE_Q = 1;
    localparam logic [TW:0] ONE_N = 1;

    logic [QW-1:0]      qcnt, scnt;
    logic [QW:0]        qnext, snext;
    logic               q_end, shuf_due;
    logic [NTHR-1:0]    lat_r;
    logic [NTHR*TW-1:0] rank_r, rank_shuf;
    logic [TW:0]        nbw_r;
    shuf_mode_e         mode_r;
    logic [15:0]        lfsr_r;

    always_comb begin
        qnext    = {1'b0, qcnt} + ONE_Q;
        snext    = {1'b0, scnt} + ONE_Q;
        q_end    = qnext >= {1'b0, qlen_i};
        shuf_due = !q_end && (sint_i != '0) && (snext >= {1'b0, sint_i});
    end

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        always_comb begin
            if (lat_r[g])
                rank_shuf[g*TW +: TW] = rank_r[g*TW +: TW];
            else if (mode_r == SHUF_INSERT)
                rank_shuf[g*TW +: TW] = TW'(ins_map(int'(rank_r[g*TW +: TW]), int'(nbw_r)));
            else
                rank_shuf[g*TW +: TW] = TW'(rnd_map(int'(rank_r[g*TW +: TW]), int'(nbw_r),
                                                    lfsr_r, NTHR));
        end

        // R3: a bandwidth thread's rank lies inside its group
        a_r3_rank_in_group: assert property (@(posedge clk) disable iff (rst)
            !lat_r[g] |-> ({1'b0, rank_r[g*TW +: TW]} < nbw_r));

        // R5: insertion wraps the top-ranked thread to the bottom
        a_r5_top_wraps: assert property (@(posedge clk) disable iff (rst)
            (shuf_due && mode_r == SHUF_INSERT && !lat_r[g] &&
             {1'b0, rank_r[g*TW +: TW]} == nbw_r - ONE_N)
            |=> (rank_r[g*TW +: TW] == '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qcnt   <= '0;
            scnt   <= '0;
            lat_r  <= '1;
            rank_r <= '0;
            nbw_r  <= '0;
            mode_r <= SHUF_INSERT;
            lfsr_r <= LFSR_SEED;
        end else if (q_end) begin
            qcnt   <= '0;
            scnt   <= '0;
            lat_r  <= snap_lat_i;
            rank_r <= snap_rank_i;
            nbw_r  <= snap_nbw_i;
            mode_r <= snap_ins_i ? SHUF_INSERT : SHUF_RANDOM;
        end else begin
            qcnt <= qnext[QW-1:0];
            if (shuf_due) begin
                scnt   <= '0;
                rank_r <= rank_shuf;
                if (mode_r == SHUF_RANDOM) lfsr_r <= lfsr_next(lfsr_r);
            end else begin
                scnt <= snext[QW-1:0];
            end
        end
    end

    assign lat_o  = lat_r;
    assign rank_o = rank_r;

    // R7: nothing moves between quantum ends and shuffles
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!q_end && !shuf_due) |=> ($stable(rank_r) && $stable(lat_r)));

    // R6: the LFSR only steps on a random shuffle
    a_r6_lfsr_still: assert property (@(posedge clk) disable iff (rst)
        !(shuf_due && mode_r == SHUF_RANDOM) |=> $stable(lfsr_r));

endmodule

// File: rtl/ctpa_grant.sv
module ctpa_grant #(
    parameter  int NTHR = 8,
    parameter  int NREQ = 8,
    localparam int TW   = $clog2(NTHR),
    localparam int PW   = TW + 1
) (
    input  logic [NTHR*PW-1:0] prio_i,
    input  logic [NREQ-1:0]    vld_i,
    input  logic [NREQ*TW-1:0] tid_i,
    output logic [NREQ-1:0]    gnt_o
);

    logic [PW-1:0]    prio_a [NTHR];
    logic [TW-1:0]    tid;
    logic [PW+TW-1:0] key, best;
    logic             found;
    int               idx;

    for (genvar g = 0; g < NTHR; g++) begin : g_unpack
        assign prio_a[g] = prio_i[g*PW +: PW];
    end

    // key = {priority, inverted ID}: larger key wins, first entry on a tie
    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        best  = '0;
        idx   = 0;
        tid   = '0;
        key   = '0;
        for (int e = 0; e < NREQ; e++) begin
            tid = tid_i[e*TW +: TW];
            key = {prio_a[tid], ~tid};
            if (vld_i[e] && (!found || key > best)) begin
                found = 1'b1;
                best  = key;
                idx   = e;
            end
        end
        if (found) gnt_o[idx] = 1'b1;
    end

endmodule

// File: rtl/ctpa_arbiter.sv
module ctpa_arbiter #(
    parameter  int NTHR   = 8,
    parameter  int CNT_W  = 8,
    parameter  int QLEN_W = 16,
    parameter  int NREQ   = 8,
    localparam int TW     = $clog2(NTHR),
    localparam int PW     = TW + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NTHR*CNT_W-1:0] intensity_i,
    input  logic [NTHR*CNT_W-1:0] hit_rate_i,
    input  logic [NTHR*CNT_W-1:0] blp_i,
    input  logic [CNT_W-1:0]      int_thresh_i,
    input  logic [TW:0]           gap_thresh_i,
    input  logic [QLEN_W-1:0]     quantum_len_i,
    input  logic [QLEN_W-1:0]     shuffle_int_i,
    input  logic [NREQ-1:0]       req_valid_i,
    input  logic [NREQ*TW-1:0]    req_tid_i,
    output logic [NTHR*PW-1:0]    prio_o,
    output logic [NREQ-1:0]       grant_o
);

    logic [NTHR-1:0]    snap_lat, lat_w;
    logic [NTHR*TW-1:0] snap_rank, rank_w;
    logic [TW:0]        snap_nbw;
    logic               snap_ins;

    ctpa_ranker #(.NTHR(NTHR), .CW(CNT_W)) i_ranker (
        .intensity_i (intensity_i),
        .hit_i       (hit_rate_i),
        .blp_i       (blp_i),
        .thr_i       (int_thresh_i),
        .gap_thr_i   (gap_thresh_i),
        .lat_o       (snap_lat),
        .rank_o      (snap_rank),
        .nbw_o       (snap_nbw),
        .ins_o       (snap_ins)
    );

    ctpa_rank_state #(.NTHR(NTHR), .QW(QLEN_W)) i_state (
        .clk         (clk),
        .rst         (rst),
        .qlen_i      (quantum_len_i),
        .sint_i      (shuffle_int_i),
        .snap_lat_i  (snap_lat),
        .snap_rank_i (snap_rank),
        .snap_nbw_i  (snap_nbw),
        .snap_ins_i  (snap_ins),
        .lat_o       (lat_w),
        .rank_o      (rank_w)
    );

    for (genvar g = 0; g < NTHR; g++) begin : g_prio
        assign prio_o[g*PW +: PW] = lat_w[g] ? PW'(NTHR) : {1'b0, rank_w[g*TW +: TW]};
    end

    ctpa_grant #(.NTHR(NTHR), .NREQ(NREQ)) i_grant (
        .prio_i (prio_o),
        .vld_i  (req_valid_i),
        .tid_i  (req_tid_i),
        .gnt_o  (grant_o)
    );

    // R8: at most one entry granted, and only valid ones
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o) && ((grant_o & ~req_valid_i) == '0));

    // R8: some entry is granted whenever one is pending
    a_r8_serves: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i != '0) |-> (grant_o != '0));

endmodule

// File: tb/test_ctpa_arbiter.sv
`timescale 1ns/1ps
module test_ctpa_arbiter;

    localparam int NT = 8;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] inten_b = '0, hit_b = '0, blp_b = '0;
    logic [7:0]  thr_b = '0;
    logic [3:0]  gap_b = '0;
    logic [15:0] qlen_b = 16'd4, sint_b = '0;
    logic [7:0]  rv_b = '0;
    logic [23:0] rt_b = '0;
    logic [31:0] prio_w;
    logic [7:0]  gnt_w;

    int errs = 0, checks = 0;
    bit done = 0;
    string tag = "R9";

    // reference model state
    int          m_lat [NT];
    int          m_rank[NT];
    int          m_nbw, m_mode, m_q, m_s;   // m_mode: 0 insertion, 1 random
    logic [15:0] m_lfsr;

    always #2.5 clk = ~clk;

    ctpa_arbiter i_ctpa_arbiter (
        .clk(clk), .rst(rst), .intensity_i(inten_b), .hit_rate_i(hit_b), .blp_i(blp_b),
        .int_thresh_i(thr_b), .gap_thresh_i(gap_b), .quantum_len_i(qlen_b),
        .shuffle_int_i(sint_b), .req_valid_i(rv_b), .req_tid_i(rt_b),
        .prio_o(prio_w), .grant_o(gnt_w));

    function automatic int cval(logic [63:0] b, int i);
        return int'(b[i*8 +: 8]);
    endfunction

    task automatic m_snapshot();
        int hr[NT], br[NT], nice[NT];
        bit placed[NT];
        int mx, mn, best;
        m_nbw = 0;
        for (int i = 0; i < NT; i++) begin
            m_lat[i] = (cval(inten_b, i) < int'(thr_b)) ? 1 : 0;
            if (m_lat[i] == 0) m_nbw++;
            hr[i] = 0; br[i] = 0;
            for (int j = 0; j < NT; j++) begin
                if (cval(hit_b, j) < cval(hit_b, i) || (cval(hit_b, j) == cval(hit_b, i) && j < i)) hr[i]++;
                if (cval(blp_b, j) < cval(blp_b, i) || (cval(blp_b, j) == cval(blp_b, i) && j < i)) br[i]++;
            end
            nice[i] = br[i] - hr[i];
            m_rank[i] = 0;
            placed[i] = 0;
        end
        // selection from the top: nicest first, lowest ID first on ties
        for (int pos = m_nbw - 1; pos >= 0; pos--) begin
            best = -1;
            for (int i = 0; i < NT; i++)
                if (m_lat[i] == 0 && !placed[i] && (best < 0 || nice[i] > nice[best])) best = i;
            placed[best] = 1;
            m_rank[best] = pos;
        end
        mx = -100; mn = 100;
        for (int i = 0; i < NT; i++)
            if (m_lat[i] == 0) begin
                if (nice[i] > mx) mx = nice[i];
                if (nice[i] < mn) mn = nice[i];
            end
        m_mode = (m_nbw == 0 || (mx - mn) > int'(gap_b)) ? 0 : 1;
    endtask

    task automatic m_shuffle();
        int t[NT], a, b;
        if (m_mode == 0) begin
            for (int i = 0; i < NT; i++)
                if (m_lat[i] == 0) m_rank[i] = (m_rank[i] == m_nbw - 1) ? 0 : m_rank[i] + 1;
        end else begin
            for (int r = 0; r < NT; r++) t[r] = r;
            for (int p = 0; p < 7; p++) begin
                a = (p < 4) ? 2 * p : 2 * (p - 4) + 1;
                b = a + 1;
                if (b < m_nbw && m_lfsr[p])
                    for (int r = 0; r < NT; r++) begin
                        if (t[r] == a) t[r] = b;
                        else if (t[r] == b) t[r] = a;
                    end
            end
            for (int i = 0; i < NT; i++)
                if (m_lat[i] == 0) m_rank[i] = t[m_rank[i]];
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
    endtask

    task automatic m_update();
        if (rst) begin
            for (int i = 0; i < NT; i++) begin m_lat[i] = 1; m_rank[i] = 0; end
            m_nbw = 0; m_mode = 0; m_q = 0; m_s = 0; m_lfsr = 16'hACE1;
        end else if (m_q + 1 >= int'(qlen_b)) begin
            m_snapshot();
            m_q = 0; m_s = 0;
        end else begin
            m_q++;
            if (sint_b != 0 && m_s + 1 >= int'(sint_b)) begin
                m_shuffle();
                m_s = 0;
            end else m_s++;
        end
    endtask

    function automatic int m_prio(int i);
        return (m_lat[i] != 0) ? NT : m_rank[i];
    endfunction

    task automatic compare();
        int bp, bt, be, tid;
        logic [7:0] eg;
        for (int i = 0; i < NT; i++) begin
            checks++;
            if (int'(prio_w[i*4 +: 4]) != m_prio(i)) begin
                errs++;
                $display("FAIL %s thread %0d prio actual=%0d expected=%0d", tag, i,
                         prio_w[i*4 +: 4], m_prio(i));
            end
        end
        bp = -1; bt = NT; be = -1;
        for (int e = 0; e < NR; e++)
            if (rv_b[e]) begin
                tid = int'(rt_b[e*3 +: 3]);
                if (m_prio(tid) > bp) bp = m_prio(tid);
            end
        for (int e = 0; e < NR; e++)
            if (rv_b[e] && m_prio(int'(rt_b[e*3 +: 3])) == bp && int'(rt_b[e*3 +: 3]) < bt)
                bt = int'(rt_b[e*3 +: 3]);
        for (int e = NR - 1; e >= 0; e--)
            if (rv_b[e] && int'(rt_b[e*3 +: 3]) == bt) be = e;
        eg = (be >= 0) ? 8'(1 << be) : 8'h00;
        checks++;
        if (gnt_w !== eg) begin
            errs++;
            $display("FAIL R8 (%s) grant actual=%b expected=%b", tag, gnt_w, eg);
        end
    endtask

    task automatic step();
        @(posedge clk);
        m_update();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(int cmax, int imax, int vpct);
        for (int i = 0; i < NT; i++) begin
            inten_b[i*8 +: 8] = 8'($urandom_range(imax, 0));
            hit_b[i*8 +: 8]   = 8'($urandom_range(cmax, 0));
            blp_b[i*8 +: 8]   = 8'($urandom_range(cmax, 0));
        end
        for (int e = 0; e < NR; e++) begin
            rv_b[e] = ($urandom_range(99, 0) < vpct);
            rt_b[e*3 +: 3] = 3'($urandom_range(7, 0));
        end
    endtask

    task automatic run(int n, int cmax, int imax, int vpct);
        for (int k = 0; k < n; k++) begin
            drive(cmax, imax, vpct);
            step();
        end
    endtask

    initial begin
        // R9: reset state
        tag = "R9";
        rst = 1'b1;
        run(3, 255, 255, 60);
        rst = 1'b0;
        // R3: base ranking, no shuffles
        tag = "R3"; qlen_b = 4; sint_b = 0; thr_b = 128; gap_b = 15;
        run(60, 255, 255, 60);
        run(40, 2, 255, 60);
        // R2: grouping boundaries
        tag = "R2"; thr_b = 0;   run(20, 255, 255, 60);
        thr_b = 255;             run(20, 255, 254, 60);
        thr_b = 100;
        for (int k = 0; k < 30; k++) begin
            drive(255, 255, 60);
            for (int i = 0; i < NT; i++) inten_b[i*8 +: 8] = 8'(99 + $urandom_range(2, 0));
            step();
        end
        // R5: insertion shuffles
        tag = "R5"; thr_b = 128; gap_b = 0; qlen_b = 25; sint_b = 3;
        run(150, 255, 255, 60);
        // R6: random shuffles, with niceness ties
        tag = "R6"; gap_b = 15; sint_b = 2;
        run(200, 3, 255, 60);
        // R4: method chosen per quantum
        tag = "R4"; gap_b = 6; qlen_b = 10;
        run(200, 255, 255, 60);
        // R7: shuffle timing
        tag = "R7"; qlen_b = 30; sint_b = 1; run(100, 255, 255, 60);
        sint_b = 0;                          run(50, 255, 255, 60);
        qlen_b = 5; sint_b = 7;              run(50, 255, 255, 60);
        // R1: quantum lengths
        tag = "R1"; sint_b = 2; qlen_b = 0; run(40, 255, 255, 60);
        qlen_b = 1;                         run(40, 255, 255, 60);
        qlen_b = 7;                         run(80, 255, 255, 60);
        // R8: sparse requests, ties among latency threads
        tag = "R8"; thr_b = 255; run(40, 255, 0, 25);
        thr_b = 128;             run(60, 255, 255, 20);
        // R9: reset again mid-run
        tag = "R9"; rst = 1'b1; run(2, 255, 255, 60);
        rst = 1'b0; run(20, 255, 255, 60);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule